// File: doc/BRIEF.md
# Single-Register MDIO Management Master

This block runs clause-22 management frames toward an Ethernet PHY. Software controls it through one 32-bit command/status word. Software writes a word with the request flag set, and the block sends one complete frame on the management clock and data lines. The frame is either a register write or a register read. When the frame is done, the block clears the request flag.

For a read, the 16 bits that the PHY returns replace the low half of the same word. Software polls the request flag and picks up the result as soon as the flag reads zero.

The management clock comes from the system clock through a divider set at build time. The data line changes on each falling edge of the management clock. Read data is sampled on each rising edge.

Top module: `mgmt_cmd_master`

## Requirements
- R1: After reset, `rd_data` is all zeros, `mdc` is low and `mdio_oe` is low.
- R2: A write accepted while idle with bit 31 set starts a frame. Bit 31 reads 1 for exactly 128*DIV_HALF cycles after the accepting edge and then reads 0.
- R3: A write accepted while idle with bit 31 clear stores the word into `rd_data` and starts no frame: `mdc` stays low and `mdio_oe` stays low.
- R4: While bit 31 reads 1, writes are ignored and `rd_data` does not change until the frame completes.
- R5: `mdc` is low while idle. During a frame it toggles every DIV_HALF system cycles, beginning low, for 64 full periods.
- R6: The frame carries 64 bits, most significant first, one bit per `mdc` period, in this order:
  - 32 ones;
  - start code 01;
  - opcode 10 for a read or 01 for a write, where bit 30 = 1 selects a read;
  - PHY address from bits 25:21;
  - register address from bits 20:16;
  - 2 turnaround bits;
  - 16 data bits.
- R7: While driven, `mdio_o` changes only in the cycle in which `mdc` falls.
- R8: `mdio_oe` is low whenever no frame is running. During a read it is low from bit 46 (the turnaround) to the end of the frame.
- R9: For a read, bits 15:0 keep their written value while busy. In the cycle in which bit 31 clears, they take the 16 bits sampled on `mdio_i` at the rising `mdc` edges of bits 48 to 63, first sample in bit 15.
- R10: For a write, the turnaround is driven as 1 then 0, followed by bits 15:0 of the command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the command word |
| wr_data | input | 32 | Command word to write |
| rd_data | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A wrong bit counter or divider state shows up at the ports within one `mdc` half-period. It appears as an `mdc` edge in the wrong cycle, a misplaced address bit on `mdio_o`, or the output enable dropping at the wrong bit. A wrong capture register stays hidden until the frame ends, and then shows in the low half of `rd_data` in the cycle the busy flag clears. A busy flag that clears early or late shows in that same cycle. A missed write lock shows as soon as `rd_data` changes mid-frame.

// File: rtl/mgmt_cmd_master.sv
module mgmt_cmd_master #(
  parameter int DIV_HALF = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [31:0]   cmd_q;
  logic [DW-1:0] div_q;
  logic          mdc_q;
  logic [5:0]    idx_q;
  logic [15:0]   cap_q;
  logic [63:0]   frame;

  wire busy  = cmd_q[31];
  wire is_rd = cmd_q[30];
  wire tick  = busy && (div_q == DIV_LAST);
  wire rise  = tick && !mdc_q;
  wire fall  = tick && mdc_q;

  assign frame = {32'hFFFF_FFFF, 2'b01, is_rd ? 2'b10 : 2'b01,
                  cmd_q[25:21], cmd_q[20:16],
                  is_rd ? 2'b11 : 2'b10,
                  is_rd ? 16'hFFFF : cmd_q[15:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      div_q <= '0;
      mdc_q <= 1'b0;
      idx_q <= '0;
      cap_q <= '0;
    end else if (!busy) begin
      div_q <= '0;
      mdc_q <= 1'b0;
      idx_q <= '0;
      if (wr_en) cmd_q <= wr_data;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick) mdc_q <= ~mdc_q;
      if (rise && is_rd && idx_q >= 6'd48) cap_q <= {cap_q[14:0], mdio_i};
      if (fall) begin
        if (idx_q == 6'd63) begin
          cmd_q[31] <= 1'b0;
          if (is_rd) cmd_q[15:0] <= cap_q;
        end else begin
          idx_q <= idx_q + 6'd1;
        end
      end
    end
  end

  assign rd_data = cmd_q;
  assign mdc     = mdc_q;
  assign mdio_o  = frame[6'd63 - idx_q];
  assign mdio_oe = busy && !(is_rd && idx_q >= 6'd46);
endmodule

// File: rtl/mgmt_cmd_master_chk.sv
module mgmt_cmd_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] rd_data,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> !mdc); // R5

  AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[31] |-> !mdio_oe); // R8

  AST_WORD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[31]) && rd_data[31]) |-> $stable(rd_data)); // R4

  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_data[31]) && rd_data[31] && $past(mdio_oe) && mdio_oe && !$fell(mdc))
      |-> $stable(mdio_o)); // R7
endmodule

bind mgmt_cmd_master mgmt_cmd_master_chk u_chk (.*);

// File: tb/sim_mgmt_cmd_master.sv
`timescale 1ns/1ps
module sim_mgmt_cmd_master;
  localparam int HALF = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] m_reg = '0;
  logic        m_busy = 1'b0;
  logic        m_rd = 1'b0;
  logic [63:0] m_fv = '0;
  logic [15:0] phy_val = '0;
  int          k = 0;
  logic        p_valid = 1'b0;
  logic        p_o = 1'b0, p_oe = 1'b0, p_mdc = 1'b0;

  always #10 clk = ~clk;

  mgmt_cmd_master #(.DIV_HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    int tg, idx;
    logic e_mdc, e_oe, e_o;
    #1;
    cycles++;
    if (!rst_n) begin
      m_reg = '0; m_busy = 1'b0; k = 0; p_valid = 1'b0;
    end else begin
      if (m_busy) begin
        k++;
        if (k == 128 * HALF) begin
          m_busy = 1'b0;
          m_reg[31] = 1'b0;
          if (m_rd) m_reg[15:0] = phy_val;
        end
      end else if (wr_en) begin
        m_reg = wr_data;
        if (wr_data[31]) begin
          m_busy = 1'b1; k = 0; m_rd = wr_data[30];
          m_fv = {32'hFFFF_FFFF, 2'b01, (m_rd ? 2'b10 : 2'b01), wr_data[25:21], wr_data[20:16],
                  (m_rd ? 2'b11 : 2'b10), (m_rd ? 16'hFFFF : wr_data[15:0])};
        end
      end
      tg = m_busy ? k / HALF : 0;
      idx = tg / 2;
      e_mdc = m_busy && (tg % 2 == 1);
      e_oe = m_busy && !(m_rd && idx >= 46);
      e_o = m_fv[63 - idx];
      mdio_i = (m_busy && m_rd && idx >= 48) ? phy_val[63 - idx] : 1'b1;

      if (rd_data[31] !== m_reg[31]) check(1'b0, "R2", rd_data, m_reg);
      else if (rd_data[15:0] !== m_reg[15:0]) check(1'b0, "R9", rd_data, m_reg);
      else check(rd_data === m_reg, "R3", rd_data, m_reg);
      check(mdc === e_mdc, "R5", {31'd0, mdc}, {31'd0, e_mdc});
      check(mdio_oe === e_oe, "R8", {31'd0, mdio_oe}, {31'd0, e_oe});
      if (e_oe)
        check(mdio_o === e_o, (!m_rd && idx >= 46) ? "R10" : "R6", {26'd0, idx[5:0]}, {31'd0, e_o});
      if (p_valid && e_oe && p_oe && !(p_mdc && !e_mdc))
        check(mdio_o === p_o, "R7", {31'd0, mdio_o}, {31'd0, p_o});
      p_valid = 1'b1; p_o = mdio_o; p_oe = e_oe; p_mdc = e_mdc;
    end
  end

  task automatic put(input logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    while (rd_data[31]) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] cmd(input bit rd, input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] d);
    return {1'b1, rd, 4'b0, pa, ra, d};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data === 32'd0, "R1", rd_data, 32'd0);
    check(mdc === 1'b0 && mdio_oe === 1'b0, "R1", {30'd0, mdc, mdio_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    put(32'h0012_3456);                      // R3: stored, no frame
    repeat (20) @(negedge clk);
    check(rd_data === 32'h0012_3456 && mdc === 1'b0, "R3", rd_data, 32'h0012_3456);
    phy_val = 16'hA5C3;
    put(cmd(1'b1, 5'h13, 5'h0A, 16'hBEEF));  // read
    repeat (10) @(negedge clk);
    put(cmd(1'b0, 5'h02, 5'h03, 16'h1111));  // R4: ignored while busy
    wait_idle();
    check(rd_data === {6'b010000, 5'h13, 5'h0A, 16'hA5C3}, "R9", rd_data, {6'b010000, 5'h13, 5'h0A, 16'hA5C3});
    put(cmd(1'b0, 5'h01, 5'h1F, 16'h8001));  // write
    wait_idle();
    check(rd_data === {6'b000000, 5'h01, 5'h1F, 16'h8001}, "R4", rd_data, {6'b000000, 5'h01, 5'h1F, 16'h8001});
    phy_val = 16'h0000;
    put(cmd(1'b1, 5'h00, 5'h00, 16'hFFFF));
    wait_idle();
    phy_val = 16'hFFFF;
    put(cmd(1'b1, 5'h1F, 5'h1F, 16'h0000));
    wait_idle();
    put(cmd(1'b0, 5'h15, 5'h0A, 16'h5AA5));
    while (rd_data[31]) @(negedge clk);
    phy_val = 16'h3C96;
    put(cmd(1'b1, 5'h0A, 5'h15, 16'h1234)); // back to back
    wait_idle();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule